// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A controller pulses `burst_go` together with the first column, a three-bit length code, an ordering select and the direction of the access. From the next cycle on, the block presents one column per clock on `col_out` with `beat_valid` high. It flags the final beat of a fixed-length burst on `beat_last`.

Fixed-length bursts stay inside the naturally aligned block of the burst length. Only the low log2(length) column bits move, and the upper bits keep their start values. In sequential order the low bits count upward and wrap. In interleaved order the low bits are the start offset XOR the beat index. A full-page burst sweeps the whole column space in sequential order and keeps wrapping until a halt arrives. Two further controls can shorten a burst: a single-beat-write control turns write bursts into one beat, and a halt input stops any burst early.

Top module: `sdram_col_seq`

## Requirements
- R1: The length code on `len_code` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page (2^COL_W columns, 256 by default).
- R2: When `burst_go` is high at a rising clock edge, the next cycle shows beat 0 with `beat_valid` high and `col_out` equal to `first_col`. Each following clock edge advances one beat.
- R3: In sequential order (`order_sel`=0), the low log2(length) bits of `col_out` increment by one per beat modulo the length. The remaining upper bits equal those of `first_col` for the whole burst.
- R4: In interleaved order (`order_sel`=1), the low log2(length) bits of beat i equal the low bits of `first_col` XOR i. The upper bits stay fixed.
- R5: `beat_last` is high exactly on the final beat of a fixed-length burst. `beat_valid` is low in the cycle after that beat unless a new `burst_go` arrived.
- R6: A full-page burst ignores `order_sel` and steps `col_out` by one modulo 2^COL_W on every beat. It never raises `beat_last` and runs until halted.
- R7: When `wr_one_beat`=1 and `is_write`=1, the burst is one beat long whatever the length code. When `wr_one_beat`=1 and `is_write`=0, the burst keeps the programmed length.
- R8: When `halt` is high at a clock edge while `beat_valid` is high, no further beat follows and `beat_valid` is low in the next cycle. When `halt` is high while no burst runs, it has no effect.
- R9: The reserved codes 3'b100, 3'b101 and 3'b110 produce a one-beat burst. On that beat `len_err` is high. `len_err` is low on every beat of a burst started with a legal code.
- R10: While `rst_n` is low, and in the first cycle after reset releases, `beat_valid`, `beat_last` and `len_err` are low.
- R11: `burst_go` during a running burst abandons that burst and starts the new one on the next cycle. `burst_go` takes priority over `halt` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_go | input | 1 | Start a burst with the current settings |
| first_col | input | COL_W (8) | Column of beat 0 |
| len_code | input | 3 | Burst length code |
| order_sel | input | 1 | 0 sequential, 1 interleaved |
| is_write | input | 1 | Burst is a write |
| wr_one_beat | input | 1 | Write bursts last a single beat |
| halt | input | 1 | End the running burst |
| col_out | output | COL_W (8) | Column of the current beat (0 when idle) |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| len_err | output | 1 | Current burst was started with a reserved length code |

## Verification
A wrong latched length mask shows up on the very first wrap: a column leaves its aligned block, or `beat_last` lands on the wrong beat. Both are visible at most eight cycles after `burst_go`. A corrupted beat counter or ordering select changes `col_out` on the next beat, so every beat of every vector is compared against columns derived by hand from the ordering rules. Faults in the halt path, the single-beat write path and the start-priority path only appear one cycle after the control edge. For that reason `beat_valid` is sampled exactly there. A full-page sweep runs past the 2^COL_W wrap so that a counter carry or width fault becomes visible.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

  localparam int          LEN_CODE_W  = 3;
  localparam int          MAX_FIXED_LG = 3;

  localparam logic [LEN_CODE_W-1:0] LC_ONE   = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LC_TWO   = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LC_FOUR  = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LC_EIGHT = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LC_PAGE  = 3'b111;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ITL = 1'b1
  } col_order_e;

  // log2 of the fixed burst length; 0 for anything that is not a fixed length
  function automatic logic [1:0] code_log2(input logic [LEN_CODE_W-1:0] code);
    case (code)
      LC_TWO:   code_log2 = 2'd1;
      LC_FOUR:  code_log2 = 2'd2;
      LC_EIGHT: code_log2 = 2'd3;
      default:  code_log2 = 2'd0;
    endcase
  endfunction

  function automatic logic code_is_reserved(input logic [LEN_CODE_W-1:0] code);
    code_is_reserved = (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
  endfunction

endpackage

// File: rtl/blen_decode.sv
module blen_decode
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_sel,
  input  logic                  is_write,
  input  logic                  wr_one_beat,
  output logic [COL_W-1:0]      wrap_mask,
  output logic                  page_mode,
  output col_order_e            order,
  output logic                  rsvd_code
);

  logic       single_wr;
  logic [1:0] lg;
  logic       page_code;

  assign single_wr = is_write && wr_one_beat;
  assign rsvd_code = code_is_reserved(len_code);
  assign page_code = (len_code == LC_PAGE);
  assign page_mode = page_code && !single_wr;
  assign lg        = single_wr ? 2'd0 : code_log2(len_code);

  // interleave is not defined for full page: force sequential there
  assign order = page_mode ? ORD_SEQ : col_order_e'(order_sel);

  // per-bit mask: a bit wraps when it lies below log2(length), or always in page mode
  for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
    assign wrap_mask[gi] = page_mode || (gi < int'(lg));
  end

endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_go,
  input  logic             halt,
  input  logic [COL_W-1:0] first_col,
  input  logic [COL_W-1:0] wrap_mask_in,
  input  logic             page_in,
  input  col_order_e       order_in,
  input  logic             rsvd_in,
  output logic             active_q,
  output logic [COL_W-1:0] idx_q,
  output logic [COL_W-1:0] mask_q,
  output logic             page_q,
  output col_order_e       order_q,
  output logic             rsvd_q,
  output logic [COL_W-1:0] scol_q,
  output logic             final_beat
);

  // a fixed burst ends when the beat index reaches length-1, which equals the mask
  assign final_beat = active_q && !page_q && (idx_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      order_q  <= ORD_SEQ;
      rsvd_q   <= 1'b0;
      scol_q   <= '0;
    end else if (burst_go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      mask_q   <= wrap_mask_in;
      page_q   <= page_in;
      order_q  <= order_in;
      rsvd_q   <= rsvd_in;
      scol_q   <= first_col;
    end else if (active_q) begin
      if (halt || final_beat) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/col_map.sv
module col_map
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] scol,
  input  logic [COL_W-1:0] mask,
  input  col_order_e       order,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] map_col(
    input logic [COL_W-1:0] s,
    input logic [COL_W-1:0] m,
    input col_order_e       o,
    input logic [COL_W-1:0] i
  );
    logic [COL_W-1:0] hi, lo, mv;
    hi = s & ~m;
    lo = s & m;
    if (o == ORD_ITL) mv = (lo ^ i) & m;
    else              mv = (lo + i) & m;
    map_col = hi | mv;
  endfunction

  assign col = map_col(scol, mask, order, idx);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_go,
  input  logic [COL_W-1:0]      first_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_sel,
  input  logic                  is_write,
  input  logic                  wr_one_beat,
  input  logic                  halt,
  output logic [COL_W-1:0]      col_out,
  output logic                  beat_valid,
  output logic                  beat_last,
  output logic                  len_err
);

  localparam int MIN_COL_W = MAX_FIXED_LG;

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  col_order_e       dec_order;
  logic             dec_rsvd;

  logic             active_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  col_order_e       order_q;
  logic             rsvd_q;
  logic [COL_W-1:0] scol_q;
  logic             final_beat;
  logic [COL_W-1:0] mapped_col;

  initial begin
    if (COL_W < MIN_COL_W) $error("COL_W too small for an 8-beat burst");
  end

  blen_decode #(.COL_W(COL_W)) u_dec (
    .len_code    (len_code),
    .order_sel   (order_sel),
    .is_write    (is_write),
    .wr_one_beat (wr_one_beat),
    .wrap_mask   (dec_mask),
    .page_mode   (dec_page),
    .order       (dec_order),
    .rsvd_code   (dec_rsvd)
  );

  beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_go     (burst_go),
    .halt         (halt),
    .first_col    (first_col),
    .wrap_mask_in (dec_mask),
    .page_in      (dec_page),
    .order_in     (dec_order),
    .rsvd_in      (dec_rsvd),
    .active_q     (active_q),
    .idx_q        (idx_q),
    .mask_q       (mask_q),
    .page_q       (page_q),
    .order_q      (order_q),
    .rsvd_q       (rsvd_q),
    .scol_q       (scol_q),
    .final_beat   (final_beat)
  );

  col_map #(.COL_W(COL_W)) u_map (
    .scol  (scol_q),
    .mask  (mask_q),
    .order (order_q),
    .idx   (idx_q),
    .col   (mapped_col)
  );

  assign beat_valid = active_q;
  assign beat_last  = final_beat;
  assign len_err    = active_q && rsvd_q;
  assign col_out    = active_q ? mapped_col : '0;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_go,
  input logic [COL_W-1:0] first_col,
  input logic             halt,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             len_err,
  input logic [COL_W-1:0] mask_q,
  input logic             page_q,
  input col_order_e       order_q
);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !beat_valid && !beat_last && !len_err);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> beat_valid && (col_out == $past(first_col)));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !burst_go && !halt && !beat_last |=>
      beat_valid && ((col_out & ~mask_q) == ($past(col_out) & ~$past(mask_q))));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !burst_go && !halt && !beat_last && (order_q == ORD_SEQ) |=>
      ((col_out & mask_q) == (($past(col_out) + 1'b1) & mask_q)));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !burst_go |=> !beat_valid);

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && page_q |-> !beat_last);

  assert_halt_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && halt && !burst_go |=> !beat_valid);

  assert_err_one_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> beat_valid && beat_last);

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_go   (burst_go),
  .first_col  (first_col),
  .halt       (halt),
  .col_out    (col_out),
  .beat_valid (beat_valid),
  .beat_last  (beat_last),
  .len_err    (len_err),
  .mask_q     (mask_q),
  .page_q     (page_q),
  .order_q    (order_q)
);

// File: tb/sdram_col_seq_tb_top.sv
module sdram_col_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_go = 1'b0;
  logic [7:0] first_col = '0;
  logic [2:0] len_code = '0;
  logic       order_sel = 1'b0;
  logic       is_write = 1'b0;
  logic       wr_one_beat = 1'b0;
  logic       halt = 1'b0;
  logic [7:0] col_out;
  logic       beat_valid, beat_last, len_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sdram_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .burst_go(burst_go), .first_col(first_col),
    .len_code(len_code), .order_sel(order_sel), .is_write(is_write),
    .wr_one_beat(wr_one_beat), .halt(halt), .col_out(col_out),
    .beat_valid(beat_valid), .beat_last(beat_last), .len_err(len_err)
  );

  // vector table: start column, code, order, write, single-beat write, length, err, columns
  localparam int NV = 12;
  localparam logic [7:0]  T_COL [NV] = '{8'h41, 8'h42, 8'h45, 8'h13, 8'h7F, 8'h3C,
                                         8'h21, 8'h56, 8'h56, 8'h09, 8'h2B, 8'h62};
  localparam logic [2:0]  T_CODE[NV] = '{3'b010, 3'b010, 3'b011, 3'b010, 3'b001, 3'b011,
                                         3'b000, 3'b010, 3'b010, 3'b101, 3'b001, 3'b010};
  localparam logic        T_ORD [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam logic        T_WR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam logic        T_ONE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam int          T_LEN [NV] = '{4, 4, 8, 4, 2, 8, 1, 1, 4, 1, 2, 4};
  localparam logic        T_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h4142434000000000,   // R3 seq len4 offset 1
    64'h4243404100000000,   // R3 seq len4 offset 2
    64'h4544474641404342,   // R4 itl len8 offset 5
    64'h1312111000000000,   // R4 itl len4 offset 3
    64'h7F7E000000000000,   // R3 seq len2 wrap
    64'h3C3D3E3F38393A3B,   // R3 seq len8 offset 4
    64'h2100000000000000,   // R1 len1
    64'h5600000000000000,   // R7 write single beat
    64'h5657545500000000,   // R7 read keeps length
    64'h0900000000000000,   // R9 reserved code
    64'h2B2A000000000000,   // R4 itl len2
    64'h6263606100000000    // R4 itl len4 offset 2
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go(input logic [7:0] c, input logic [2:0] code, input logic o,
                    input logic w, input logic one);
    burst_go = 1'b1; first_col = c; len_code = code; order_sel = o;
    is_write = w; wr_one_beat = one;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: outputs idle in and right after reset
    repeat (3) @(negedge clk);
    check("R10", "valid in reset", 32'(beat_valid), 0);
    check("R10", "last in reset", 32'(beat_last), 0);
    check("R10", "err in reset", 32'(len_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "valid after reset", 32'(beat_valid), 0);

    // table walk: R1 R2 R3 R4 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      go(T_COL[v], T_CODE[v], T_ORD[v], T_WR[v], T_ONE[v]);
      @(negedge clk);
      burst_go = 1'b0;
      for (int b = 0; b < T_LEN[v]; b++) begin
        check("R2", "valid beat", 32'(beat_valid), 1);
        check("R1/R3/R4", "column", 32'(col_out), 32'(T_EXP[v][63-8*b -: 8]));
        check("R5", "last flag", 32'(beat_last), 32'(b == T_LEN[v] - 1));
        check("R9", "err flag", 32'(len_err), 32'(T_ERR[v]));
        @(negedge clk);
      end
      check("R5", "valid after last", 32'(beat_valid), 0);
    end

    // R6: full page, interleave select ignored, wraps past 255, never last
    go(8'hFE, 3'b111, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    burst_go = 1'b0;
    for (int b = 0; b < 300; b++) begin
      check("R6", "page valid", 32'(beat_valid), 1);
      check("R6", "page column", 32'(col_out), 32'((8'hFE + b) & 8'hFF));
      check("R6", "page last", 32'(beat_last), 0);
      if (b < 299) @(negedge clk);
    end
    halt = 1'b1;                         // R8 ends a full page burst
    @(negedge clk);
    halt = 1'b0;
    check("R8", "page halted", 32'(beat_valid), 0);

    // R8: halt in the middle of an 8-beat burst
    go(8'h30, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    burst_go = 1'b0;
    check("R8", "beat0", 32'(col_out), 32'h30);
    @(negedge clk);
    check("R8", "beat1", 32'(col_out), 32'h31);
    @(negedge clk);
    check("R8", "beat2", 32'(col_out), 32'h32);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check("R8", "valid after halt", 32'(beat_valid), 0);
    check("R8", "col after halt", 32'(col_out), 0);

    // R8: halt while idle has no effect
    halt = 1'b1;
    repeat (2) @(negedge clk);
    halt = 1'b0;
    check("R8", "idle halt valid", 32'(beat_valid), 0);
    go(8'hA5, 3'b000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    burst_go = 1'b0;
    check("R8", "burst after idle halt", 32'(col_out), 32'hA5);
    @(negedge clk);

    // R11: restart mid-burst, start wins over halt
    go(8'h10, 3'b010, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    burst_go = 1'b0;
    check("R11", "old beat0", 32'(col_out), 32'h10);
    @(negedge clk);
    check("R11", "old beat1", 32'(col_out), 32'h11);
    go(8'h83, 3'b001, 1'b0, 1'b0, 1'b0);
    halt = 1'b1;
    @(negedge clk);
    burst_go = 1'b0; halt = 1'b0;
    check("R11", "new beat0 valid", 32'(beat_valid), 1);
    check("R11", "new beat0", 32'(col_out), 32'h83);
    @(negedge clk);
    check("R11", "new beat1", 32'(col_out), 32'h82);
    check("R11", "new last", 32'(beat_last), 1);
    @(negedge clk);
    check("R11", "new done", 32'(beat_valid), 0);

    // R9 and R7 together: reserved code on single-beat write still flags
    go(8'h77, 3'b110, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    burst_go = 1'b0;
    check("R9", "reserved single err", 32'(len_err), 1);
    check("R9", "reserved single col", 32'(col_out), 32'h77);
    @(negedge clk);
    check("R9", "reserved single end", 32'(beat_valid), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule